// File: doc/BRIEF.md
# IQ Quad-Word Packer

This block gathers I/Q samples from four receive channels, two gain-control paths and their two signal-strength words. It packs them into 16-byte quad-words for a byte-serial link transmitter. A quad-word holds four 4-byte slots. Each slot carries a 16-bit I field followed by a 16-bit Q field, or else a padded signal-strength word. A 3-bit format input picks which sources fill the four slots. A port-select input picks the channel pair, or the gain path, that a given port carries. One format code is not allowed: the block reports it and forms nothing while it is applied.

Slots are filled one at a time, in slot order. Each slot is filled from the strobed sample of the source assigned to it. When the fourth slot is taken, the whole word moves into an output register. That register presents the word with a valid/ready handshake. Changing the format or the port select discards a part-built word.

Top module: `iq_qword_packer`

## Requirements
- R1: After reset, `qw_valid` and `cfg_err` are 0.
- R2: Slot 0 occupies `qw_data[127:96]` and slot 3 occupies `qw_data[31:0]`, so the first byte on the link is bits [127:120]. Within a slot the I field is the upper 16 bits and Q the lower, each most significant byte first.
- R3: Format codes 3'b000 and 3'b100 (bit 0 = 0, bit 1 = 0) fill slots 0..3 from channels 0, 1, 2, 3 in that order.
- R4: Format codes with bit 0 = 0 and bit 1 = 1 alternate a channel pair: channels 0,2,0,2 when `port_b` = 0 and channels 1,3,1,3 when `port_b` = 1.
- R5: Format 3'b001 puts four successive IQ pairs from one gain path into the slots: path A when `port_b` = 0 and path B when `port_b` = 1.
- R6: Format 3'b011 fills the slots with path A IQ, path A strength, path B IQ, path B strength. A strength slot is the 12-bit word in bits [31:20] of the slot with all lower 20 bits zero.
- R7: Format 3'b111 fills the slots with path A IQ, path B IQ, path A IQ, path B IQ.
- R8: Format 3'b101 is invalid. `cfg_err` is 1 from the cycle after it is applied, and no slot is taken and no quad-word is formed while it is applied.
- R9: A slot is taken only in a cycle in which the strobe of its assigned source is high, and at most one slot is taken per cycle. Strobes of other sources are ignored.
- R10: While `qw_valid` is 1 and `qw_ready` is 0, `qw_valid` and `qw_data` hold. The fourth slot is not taken until the output register is free or is being emptied in that cycle.
- R11: A change of `fmt_cfg` or `port_b` restarts assembly at slot 0, and any partly built word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_cfg | input | 3 | Packing format code |
| port_b | input | 1 | 0 selects the A-side sources, 1 the B-side |
| ch_i | input | 4x16 | Channel I samples |
| ch_q | input | 4x16 | Channel Q samples |
| ch_vld | input | 4 | Per-channel sample strobes |
| agc_i | input | 2x16 | Gain path I samples (index 0 = A) |
| agc_q | input | 2x16 | Gain path Q samples |
| agc_vld | input | 2 | Gain path IQ strobes |
| rssi | input | 2x12 | Signal-strength words |
| rssi_vld | input | 2 | Signal-strength strobes |
| qw_data | output | 128 | Assembled quad-word |
| qw_valid | output | 1 | Quad-word available |
| qw_ready | input | 1 | Transmitter accepts the quad-word |
| cfg_err | output | 1 | Invalid format applied |

## Verification
The bench builds the block with its default 16-bit sample width and 12-bit strength width. With these widths a strength slot has exactly 20 padding zeros, and the byte positions named in the requirements can be checked literally. Every source carries a distinct value, so a wrong route or a slot out of order shows up as a miscompare. The same parameters let the back-pressure and format-change cases drive the fill counter through its last-slot boundary.

// File: rtl/iqp_pkg.sv
package iqp_pkg;
  localparam int NUM_CH   = 4;
  localparam int NUM_AGC  = 2;
  localparam int NUM_SLOT = 4;
  localparam int NUM_SRC  = NUM_CH + 2 * NUM_AGC;

  typedef enum logic [2:0] {
    SRC_CH0 = 3'd0,
    SRC_CH1 = 3'd1,
    SRC_CH2 = 3'd2,
    SRC_CH3 = 3'd3,
    SRC_AIQ = 3'd4,
    SRC_BIQ = 3'd5,
    SRC_ARS = 3'd6,
    SRC_BRS = 3'd7
  } src_e;

  // Code that must never produce output.
  function automatic logic fmt_is_bad(input logic [2:0] f);
    return f == 3'b101;
  endfunction

  // Source assigned to a slot for a format and port.
  function automatic src_e slot_source(input logic [2:0] f, input logic pb,
                                       input int slot);
    src_e s;
    logic odd;
    odd = slot[0];
    s = SRC_AIQ;
    if (!f[0]) begin
      if (!f[1]) s = src_e'(slot[2:0]);
      else if (!odd) s = pb ? SRC_CH1 : SRC_CH0;
      else s = pb ? SRC_CH3 : SRC_CH2;
    end else if (!f[1]) begin
      s = pb ? SRC_BIQ : SRC_AIQ;
    end else if (!f[2]) begin
      case (slot[1:0])
        2'd0: s = SRC_AIQ;
        2'd1: s = SRC_ARS;
        2'd2: s = SRC_BIQ;
        default: s = SRC_BRS;
      endcase
    end else begin
      s = odd ? SRC_BIQ : SRC_AIQ;
    end
    return s;
  endfunction
endpackage

// File: rtl/iqp_route.sv
module iqp_route
  import iqp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RSSI_W   = 12,
  parameter int IDX_W    = 2
) (
  input  logic [2:0]                         fmt,
  input  logic                               pb,
  input  logic [IDX_W-1:0]                   slot_idx,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]    ch_i,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]    ch_q,
  input  logic [NUM_CH-1:0]                  ch_vld,
  input  logic [NUM_AGC-1:0][SAMPLE_W-1:0]   agc_i,
  input  logic [NUM_AGC-1:0][SAMPLE_W-1:0]   agc_q,
  input  logic [NUM_AGC-1:0]                 agc_vld,
  input  logic [NUM_AGC-1:0][RSSI_W-1:0]     rssi,
  input  logic [NUM_AGC-1:0]                 rssi_vld,
  output logic [2*SAMPLE_W-1:0]              word,
  output logic                               stb
);
  localparam int WW = 2 * SAMPLE_W;

  function automatic logic [WW-1:0] iq_slot(input logic [SAMPLE_W-1:0] i,
                                            input logic [SAMPLE_W-1:0] q);
    return {i, q};
  endfunction

  function automatic logic [WW-1:0] strength_slot(input logic [RSSI_W-1:0] r);
    logic [WW-1:0] w;
    w = '0;
    w[WW-1 -: RSSI_W] = r;
    return w;
  endfunction

  logic [WW-1:0]      src_word [NUM_SRC];
  logic [NUM_SRC-1:0] src_stb;
  src_e               pick;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign src_word[c] = iq_slot(ch_i[c], ch_q[c]);
    assign src_stb[c]  = ch_vld[c];
  end

  for (genvar a = 0; a < NUM_AGC; a++) begin : g_agc
    assign src_word[NUM_CH + a]           = iq_slot(agc_i[a], agc_q[a]);
    assign src_stb[NUM_CH + a]            = agc_vld[a];
    assign src_word[NUM_CH + NUM_AGC + a] = strength_slot(rssi[a]);
    assign src_stb[NUM_CH + NUM_AGC + a]  = rssi_vld[a];
  end

  assign pick = slot_source(fmt, pb, int'(slot_idx));
  assign word = src_word[pick];
  assign stb  = src_stb[pick];
endmodule

// File: rtl/iqp_fill.sv
module iqp_fill #(
  parameter int SLOTS = 4,
  parameter int WW    = 32,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic [WW-1:0]         word,
  input  logic                  stb,
  input  logic                  room,
  output logic                  take_evt,
  output logic                  done_evt,
  output logic [IDX_W-1:0]      slot_idx,
  output logic [SLOTS*WW-1:0]   assembled
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [WW-1:0] held [SLOTS-1];
  logic          at_last;

  assign at_last  = slot_idx == LAST;
  assign take_evt = stb && !clear && (!at_last || room);
  assign done_evt = take_evt && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_idx <= '0;
    end else if (clear) begin
      slot_idx <= '0;
    end else if (take_evt) begin
      slot_idx <= at_last ? '0 : slot_idx + 1'b1;
    end
  end

  for (genvar k = 0; k < SLOTS - 1; k++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held[k] <= '0;
      else if (take_evt && slot_idx == IDX_W'(k)) held[k] <= word;
    end
    assign assembled[(SLOTS-k)*WW-1 -: WW] = held[k];
  end
  assign assembled[WW-1:0] = word;
endmodule

// File: rtl/iqp_emit.sv
module iqp_emit #(
  parameter int QW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] din,
  input  logic          ready,
  output logic          room,
  output logic          valid,
  output logic [QW-1:0] data
);
  assign room = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_qword_packer.sv
module iq_qword_packer
  import iqp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RSSI_W   = 12
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [2:0]                               fmt_cfg,
  input  logic                                     port_b,
  input  logic [iqp_pkg::NUM_CH-1:0][SAMPLE_W-1:0] ch_i,
  input  logic [iqp_pkg::NUM_CH-1:0][SAMPLE_W-1:0] ch_q,
  input  logic [iqp_pkg::NUM_CH-1:0]               ch_vld,
  input  logic [iqp_pkg::NUM_AGC-1:0][SAMPLE_W-1:0] agc_i,
  input  logic [iqp_pkg::NUM_AGC-1:0][SAMPLE_W-1:0] agc_q,
  input  logic [iqp_pkg::NUM_AGC-1:0]              agc_vld,
  input  logic [iqp_pkg::NUM_AGC-1:0][RSSI_W-1:0]  rssi,
  input  logic [iqp_pkg::NUM_AGC-1:0]              rssi_vld,
  output logic [iqp_pkg::NUM_SLOT*2*SAMPLE_W-1:0]  qw_data,
  output logic                                     qw_valid,
  input  logic                                     qw_ready,
  output logic                                     cfg_err
);
  localparam int WW    = 2 * SAMPLE_W;
  localparam int QW    = NUM_SLOT * WW;
  localparam int IDX_W = $clog2(NUM_SLOT);

  logic [2:0]       cfg_q;
  logic             port_q;
  logic             cfg_chg;
  logic             clear;
  logic [WW-1:0]    word;
  logic             stb;
  logic             room;
  logic             take_evt;
  logic             load_evt;
  logic [IDX_W-1:0] slot_idx;
  logic [QW-1:0]    assembled;

  assign cfg_chg = (fmt_cfg != cfg_q) || (port_b != port_q);
  assign clear   = cfg_chg || cfg_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 3'b000;
      port_q  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cfg_q   <= fmt_cfg;
      port_q  <= port_b;
      cfg_err <= fmt_is_bad(fmt_cfg);
    end
  end

  iqp_route #(.SAMPLE_W(SAMPLE_W), .RSSI_W(RSSI_W), .IDX_W(IDX_W)) u_route (
    .fmt      (cfg_q),
    .pb       (port_q),
    .slot_idx (slot_idx),
    .ch_i     (ch_i),
    .ch_q     (ch_q),
    .ch_vld   (ch_vld),
    .agc_i    (agc_i),
    .agc_q    (agc_q),
    .agc_vld  (agc_vld),
    .rssi     (rssi),
    .rssi_vld (rssi_vld),
    .word     (word),
    .stb      (stb)
  );

  iqp_fill #(.SLOTS(NUM_SLOT), .WW(WW), .IDX_W(IDX_W)) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .word      (word),
    .stb       (stb),
    .room      (room),
    .take_evt  (take_evt),
    .done_evt  (load_evt),
    .slot_idx  (slot_idx),
    .assembled (assembled)
  );

  iqp_emit #(.QW(QW)) u_emit (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .din   (assembled),
    .ready (qw_ready),
    .room  (room),
    .valid (qw_valid),
    .data  (qw_data)
  );
endmodule

// File: rtl/iqp_checker.sv
module iqp_checker #(
  parameter int SAMPLE_W = 16,
  parameter int RSSI_W   = 12,
  parameter int QW       = 128,
  parameter int IDX_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [QW-1:0]    qw_data,
  input logic             qw_valid,
  input logic             qw_ready,
  input logic             cfg_err,
  input logic             take_evt,
  input logic             load_evt,
  input logic             cfg_chg,
  input logic [IDX_W-1:0] slot_idx,
  input logic [2:0]       cfg_q
);
  localparam int ZW = 2 * SAMPLE_W - RSSI_W;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid && !qw_ready |=> qw_valid && $stable(qw_data));

  p_no_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid && !qw_ready |-> !load_evt);

  p_bad_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !take_evt && !load_evt);

  p_load_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> take_evt);

  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> slot_idx == '0);

  p_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qw_valid) && cfg_q == 3'b011 |->
      qw_data[2*SAMPLE_W*2 +: ZW] == '0 && qw_data[0 +: ZW] == '0);
endmodule

bind iq_qword_packer iqp_checker #(
  .SAMPLE_W(SAMPLE_W), .RSSI_W(RSSI_W), .QW(QW), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .qw_data  (qw_data),
  .qw_valid (qw_valid),
  .qw_ready (qw_ready),
  .cfg_err  (cfg_err),
  .take_evt (take_evt),
  .load_evt (load_evt),
  .cfg_chg  (cfg_chg),
  .slot_idx (slot_idx),
  .cfg_q    (cfg_q)
);

// File: tb/iq_qword_packer_bench.sv
module iq_qword_packer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] fmt_cfg = 3'b000;
  logic port_b = 1'b0;
  logic [3:0][15:0] ch_i, ch_q;
  logic [3:0] ch_vld = '0;
  logic [1:0][15:0] agc_i, agc_q;
  logic [1:0] agc_vld = '0;
  logic [1:0][11:0] rssi;
  logic [1:0] rssi_vld = '0;
  logic [127:0] qw_data;
  logic qw_valid;
  logic qw_ready = 1'b0;
  logic cfg_err;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  iq_qword_packer u_iq_qword_packer (
    .clk(clk), .rst_n(rst_n), .fmt_cfg(fmt_cfg), .port_b(port_b),
    .ch_i(ch_i), .ch_q(ch_q), .ch_vld(ch_vld),
    .agc_i(agc_i), .agc_q(agc_q), .agc_vld(agc_vld),
    .rssi(rssi), .rssi_vld(rssi_vld),
    .qw_data(qw_data), .qw_valid(qw_valid), .qw_ready(qw_ready),
    .cfg_err(cfg_err)
  );

  // Source codes: 0..3 channels, 4 path A IQ, 5 path B IQ, 6 A strength, 7 B strength.
  function automatic logic [31:0] slot_of(input int s);
    if (s < 4) return {ch_i[s], ch_q[s]};
    if (s < 6) return {agc_i[s-4], agc_q[s-4]};
    return {rssi[s-6], 20'h00000};
  endfunction

  function automatic logic [127:0] qw_of(input int a, input int b, input int c, input int d);
    return {slot_of(a), slot_of(b), slot_of(c), slot_of(d)};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_data(input logic [15:0] base);
    for (int k = 0; k < 4; k++) begin
      ch_i[k] = base + 16'h1110 * 16'(k + 1);
      ch_q[k] = base ^ (16'h0F01 * 16'(k + 1));
    end
    for (int a = 0; a < 2; a++) begin
      agc_i[a] = base + 16'hA0A0 + 16'(a);
      agc_q[a] = base + 16'h5C5C + 16'(a * 3);
      rssi[a]  = base[11:0] + 12'h9E1 + 12'(a * 7);
    end
  endtask

  task automatic set_cfg(input logic [2:0] f, input logic p);
    @(negedge clk);
    fmt_cfg = f;
    port_b = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    if (s < 4) ch_vld[s] = 1'b1;
    else if (s < 6) agc_vld[s-4] = 1'b1;
    else rssi_vld[s-6] = 1'b1;
    @(negedge clk);
    ch_vld = '0;
    agc_vld = '0;
    rssi_vld = '0;
  endtask

  task automatic pop();
    @(negedge clk);
    qw_ready = 1'b1;
    @(negedge clk);
    qw_ready = 1'b0;
  endtask

  task automatic fill_and_check(input string tag, input int a, input int b,
                                input int c, input int d);
    pulse(a); pulse(b); pulse(c);
    check({tag, " not ready after 3 slots"}, {127'b0, qw_valid}, 128'd0);
    pulse(d);
    check({tag, " valid"}, {127'b0, qw_valid}, 128'd1);
    check({tag, " data"}, qw_data, qw_of(a, b, c, d));
    pop();
    check({tag, " drained"}, {127'b0, qw_valid}, 128'd0);
  endtask

  task automatic t_reset();
    check("R1 qw_valid after reset", {127'b0, qw_valid}, 128'd0);
    check("R1 cfg_err after reset", {127'b0, cfg_err}, 128'd0);
  endtask

  task automatic t_four_channel();
    set_cfg(3'b000, 1'b0);
    fill_and_check("R3 four-channel", 0, 1, 2, 3);
    pulse(0); pulse(1); pulse(2); pulse(3);
    check("R2 first byte is ch0 I msb", {120'b0, qw_data[127:120]}, {120'b0, ch_i[0][15:8]});
    check("R2 last bytes are ch3 Q", {112'b0, qw_data[15:0]}, {112'b0, ch_q[3]});
    pop();
    set_cfg(3'b100, 1'b1);
    fill_and_check("R3 four-channel bit2 set", 0, 1, 2, 3);
  endtask

  task automatic t_two_channel();
    set_cfg(3'b010, 1'b0);
    fill_and_check("R4 pair port A", 0, 2, 0, 2);
    set_cfg(3'b010, 1'b1);
    fill_and_check("R4 pair port B", 1, 3, 1, 3);
  endtask

  task automatic t_dedicated();
    set_cfg(3'b001, 1'b0);
    fill_and_check("R5 dedicated A", 4, 4, 4, 4);
    set_cfg(3'b001, 1'b1);
    fill_and_check("R5 dedicated B", 5, 5, 5, 5);
  endtask

  task automatic t_both_rssi();
    set_cfg(3'b011, 1'b0);
    fill_and_check("R6 both with strength", 4, 6, 5, 7);
  endtask

  task automatic t_both_plain();
    set_cfg(3'b111, 1'b1);
    fill_and_check("R7 both without strength", 4, 5, 4, 5);
  endtask

  task automatic t_invalid();
    set_cfg(3'b101, 1'b0);
    check("R8 cfg_err raised", {127'b0, cfg_err}, 128'd1);
    for (int n = 0; n < 6; n++) pulse(4 + (n % 4));
    check("R8 no quad-word while invalid", {127'b0, qw_valid}, 128'd0);
    set_cfg(3'b000, 1'b0);
    check("R8 cfg_err cleared", {127'b0, cfg_err}, 128'd0);
  endtask

  task automatic t_wrong_strobe();
    set_cfg(3'b000, 1'b0);
    pulse(2); pulse(4); pulse(6);
    fill_and_check("R9 foreign strobes ignored", 0, 1, 2, 3);
  endtask

  task automatic t_backpressure();
    logic [127:0] first;
    set_cfg(3'b000, 1'b0);
    pulse(0); pulse(1); pulse(2); pulse(3);
    first = qw_of(0, 1, 2, 3);
    load_data(16'h3C00);
    pulse(0); pulse(1); pulse(2); pulse(3);
    check("R10 held valid", {127'b0, qw_valid}, 128'd1);
    check("R10 held data", qw_data, first);
    pop();
    check("R10 fourth slot refused while full", {127'b0, qw_valid}, 128'd0);
    pulse(3);
    check("R10 second word data", qw_data, qw_of(0, 1, 2, 3));
    pop();
  endtask

  task automatic t_restart();
    set_cfg(3'b000, 1'b0);
    pulse(0); pulse(1);
    set_cfg(3'b000, 1'b1);
    load_data(16'h7100);
    fill_and_check("R11 restart after port change", 0, 1, 2, 3);
  endtask

  initial begin
    load_data(16'h0000);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_four_channel();
    t_two_channel();
    t_dedicated();
    t_both_rssi();
    t_both_plain();
    t_invalid();
    t_wrong_strobe();
    t_backpressure();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      misses++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule